// File: doc/BRIEF.md
# Floating-Point Exception Status Recorder

This block closes out a floating-point operation. It takes the five exception flags the operation raised, the 64-bit floating-point status word in force at that moment, and the current and following program counter values. From these it decides whether the operation must trap. It then produces a rewritten status word and either an advanced program counter pair or a trap indication. The arithmetic that raises the flags lies outside the block, and so does the delivery of the trap.

The status word is owned by the surrounding pipeline. The block is given the word on every operation and returns the updated word, which the owner keeps for the next operation. When a trap is taken, more than one enabled flag may be raised. In that case only one flag is reported, chosen by a fixed priority, so that the trap handler sees exactly one cause. Flags are folded into the accrued history only when the operation retires without trapping.

All outputs are registered. They appear one clock after the request strobe, together with a one-cycle completion pulse, and they hold their values until the next request.

Top module: `fpx_status_recorder`

## Requirements
- R1: The status word layout is as follows. Trap enables are at bits 27:23, accrued flags at bits 9:5 and current flags at bits 4:0. In every field the flag order is invalid = bit 4, overflow = bit 3, underflow = bit 2, divide-by-zero = bit 1, inexact = bit 0.
- R2: `trap_taken` is 1 exactly when some raised flag has its enable bit set.
- R3: On a trap, the current field holds the raised flags ANDed with the enables. When more than one bit remains, only the highest-priority one is kept: invalid over overflow over underflow over divide-by-zero over inexact.
- R4: Without a trap, the current field holds all raised flags, and the accrued field becomes its old value ORed with the raised flags.
- R5: On a trap, the accrued field is unchanged and status bit 14 is set. Every status bit outside the current field, the accrued field and bit 14 passes through unchanged, and bit 14 passes through when there is no trap.
- R6: On a trap, `pc_out` equals `pc_in` and `npc_out` equals `npc_in`.
- R7: Without a trap, `pc_out` equals `npc_in` and `npc_out` equals `npc_in + 4`, modulo 2^64.
- R8: An operation with no raised flags clears the current field, does not trap, and advances the PC pair.
- R9: `done` is high for one cycle, in the cycle after `op_valid`. The outputs change only on the clock edge that samples `op_valid`. Reset clears `done`, `trap_taken` and all outputs to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Operation completes this cycle; sample the inputs |
| op_flags | input | 5 | Exception flags raised by the operation |
| stat_in | input | 64 | Status word before the operation |
| pc_in | input | 64 | Program counter of the operation |
| npc_in | input | 64 | Following program counter |
| done | output | 1 | One-cycle pulse: the outputs below are fresh |
| trap_taken | output | 1 | The operation traps |
| stat_out | output | 64 | Updated status word |
| pc_out | output | 64 | Updated program counter |
| npc_out | output | 64 | Updated following program counter |

## Verification
The assertions check, on every completion, the following properties:
- The completion pulse follows the strobe.
- A trap reports exactly one current flag, and that flag is among the raised and enabled ones.
- A trap keeps the PC pair, leaves the accrued field alone and marks bit 14.
- A retire without a trap moves the PC pair forward and never clears an accrued bit.
- The enable field always passes through.

The bench scenarios cover two things that no single-cycle property states. The first is which flag wins under the priority order for a given mix of raised and enabled flags. The second is the exact current and accrued values. The scenarios also cover the wrap of the following PC at the top of the address space, a pre-set bit 14 surviving a retire, and outputs holding while no request arrives.

// File: rtl/fpx_pkg.sv
package fpx_pkg;
  // number of exception flag kinds
  localparam int unsigned FLAG_W = 5;

  // flag positions inside every 5-bit field (priority follows position)
  localparam int unsigned FL_INVALID  = 4;
  localparam int unsigned FL_OVERFLOW = 3;
  localparam int unsigned FL_UNDER    = 2;
  localparam int unsigned FL_DIVZERO  = 1;
  localparam int unsigned FL_INEXACT  = 0;

  typedef logic [FLAG_W-1:0] fpx_flags_t;
endpackage

// File: rtl/fpx_trap_decide.sv
// Decides whether an operation traps and which flags it reports.
// Priority is by bit position: the highest set bit of the masked set wins.
module fpx_trap_decide #(
  parameter int unsigned NF = fpx_pkg::FLAG_W
) (
  input  logic [NF-1:0] raised,
  input  logic [NF-1:0] enables,
  output logic          trap,
  output logic [NF-1:0] report
);
  logic [NF-1:0] masked;
  logic [NF-1:0] pick;
  logic [NF:0]   above;   // above[i]: some masked bit at position >= i

  assign masked    = raised & enables;
  assign above[NF] = 1'b0;

  for (genvar i = NF - 1; i >= 0; i--) begin : g_prio
    assign pick[i]  = masked[i] & ~above[i+1];
    assign above[i] = above[i+1] | masked[i];
  end

  assign trap   = |masked;
  assign report = trap ? pick : raised;
endmodule

// File: rtl/fpx_status_merge.sv
// Rewrites the current, accrued and trap-type parts of the status word.
module fpx_status_merge #(
  parameter int unsigned STAT_W  = 64,
  parameter int unsigned NF      = fpx_pkg::FLAG_W,
  parameter int unsigned ACC_LSB = 5,
  parameter int unsigned CUR_LSB = 0,
  parameter int unsigned TT_BIT  = 14
) (
  input  logic [STAT_W-1:0] stat_old,
  input  logic [NF-1:0]     report,
  input  logic              trap,
  output logic [STAT_W-1:0] stat_new
);
  localparam int unsigned ACC_MSB = ACC_LSB + NF - 1;
  localparam int unsigned CUR_MSB = CUR_LSB + NF - 1;

  logic [NF-1:0] acc_old;
  logic [NF-1:0] acc_next;

  assign acc_old  = stat_old[ACC_MSB:ACC_LSB];
  assign acc_next = trap ? acc_old : (acc_old | report);

  always_comb begin
    stat_new                   = stat_old;
    stat_new[CUR_MSB:CUR_LSB]  = report;
    stat_new[ACC_MSB:ACC_LSB]  = acc_next;
    if (trap) stat_new[TT_BIT] = 1'b1;
  end
endmodule

// File: rtl/fpx_pc_step.sv
// Advances the program counter pair unless a trap holds it.
module fpx_pc_step #(
  parameter int unsigned PC_W    = 64,
  parameter int unsigned PC_STEP = 4
) (
  input  logic [PC_W-1:0] pc_cur,
  input  logic [PC_W-1:0] npc_cur,
  input  logic            hold,
  output logic [PC_W-1:0] pc_nxt,
  output logic [PC_W-1:0] npc_nxt
);
  localparam logic [PC_W-1:0] STEP = PC_W'(PC_STEP);

  assign pc_nxt  = hold ? pc_cur  : npc_cur;
  assign npc_nxt = hold ? npc_cur : npc_cur + STEP;
endmodule

// File: rtl/fpx_status_recorder.sv
module fpx_status_recorder #(
  parameter int unsigned STAT_W  = 64,
  parameter int unsigned PC_W    = 64,
  parameter int unsigned NF      = fpx_pkg::FLAG_W,
  parameter int unsigned ENA_LSB = 23,
  parameter int unsigned ACC_LSB = 5,
  parameter int unsigned CUR_LSB = 0,
  parameter int unsigned TT_BIT  = 14,
  parameter int unsigned PC_STEP = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              op_valid,
  input  logic [NF-1:0]     op_flags,
  input  logic [STAT_W-1:0] stat_in,
  input  logic [PC_W-1:0]   pc_in,
  input  logic [PC_W-1:0]   npc_in,
  output logic              done,
  output logic              trap_taken,
  output logic [STAT_W-1:0] stat_out,
  output logic [PC_W-1:0]   pc_out,
  output logic [PC_W-1:0]   npc_out
);
  localparam int unsigned ENA_MSB = ENA_LSB + NF - 1;
  localparam int unsigned ACC_MSB = ACC_LSB + NF - 1;
  localparam int unsigned CUR_MSB = CUR_LSB + NF - 1;

  logic              trap_c;
  logic [NF-1:0]     report_c;
  logic [STAT_W-1:0] stat_c;
  logic [PC_W-1:0]   pc_c;
  logic [PC_W-1:0]   npc_c;

  fpx_trap_decide #(.NF(NF)) u_decide (
    .raised  (op_flags),
    .enables (stat_in[ENA_MSB:ENA_LSB]),
    .trap    (trap_c),
    .report  (report_c)
  );

  fpx_status_merge #(
    .STAT_W(STAT_W), .NF(NF), .ACC_LSB(ACC_LSB), .CUR_LSB(CUR_LSB), .TT_BIT(TT_BIT)
  ) u_merge (
    .stat_old (stat_in),
    .report   (report_c),
    .trap     (trap_c),
    .stat_new (stat_c)
  );

  fpx_pc_step #(.PC_W(PC_W), .PC_STEP(PC_STEP)) u_step (
    .pc_cur  (pc_in),
    .npc_cur (npc_in),
    .hold    (trap_c),
    .pc_nxt  (pc_c),
    .npc_nxt (npc_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      done       <= 1'b0;
      trap_taken <= 1'b0;
      stat_out   <= '0;
      pc_out     <= '0;
      npc_out    <= '0;
    end else begin
      done <= op_valid;
      if (op_valid) begin
        trap_taken <= trap_c;
        stat_out   <= stat_c;
        pc_out     <= pc_c;
        npc_out    <= npc_c;
      end
    end
  end

  // ---------------- assertions ----------------
  AST_DONE_AFTER_VALID: assert property (@(posedge clk) disable iff (rst)
    op_valid |=> done);  // R9
  AST_NO_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
    !op_valid |=> !done && $stable(stat_out) && $stable(pc_out));  // R9
  AST_TRAP_CAUSE: assert property (@(posedge clk) disable iff (rst)
    op_valid |=> trap_taken == ($past(op_flags & stat_in[ENA_MSB:ENA_LSB]) != '0));  // R2
  AST_TRAP_ONE_FLAG: assert property (@(posedge clk) disable iff (rst)
    done && trap_taken |-> $countones(stat_out[CUR_MSB:CUR_LSB]) == 1);  // R3
  AST_TRAP_FLAG_LEGAL: assert property (@(posedge clk) disable iff (rst)
    op_valid |=> !trap_taken ||
      ((stat_out[CUR_MSB:CUR_LSB] & ~$past(op_flags & stat_in[ENA_MSB:ENA_LSB])) == '0));  // R3
  AST_TRAP_KEEP_ACC: assert property (@(posedge clk) disable iff (rst)
    op_valid |=> !trap_taken ||
      (stat_out[ACC_MSB:ACC_LSB] == $past(stat_in[ACC_MSB:ACC_LSB]) && stat_out[TT_BIT]));  // R5
  AST_ACC_MONOTONE: assert property (@(posedge clk) disable iff (rst)
    op_valid |=> trap_taken ||
      ((stat_out[ACC_MSB:ACC_LSB] & $past(stat_in[ACC_MSB:ACC_LSB])) ==
        $past(stat_in[ACC_MSB:ACC_LSB])));  // R4
  AST_ENA_PASS: assert property (@(posedge clk) disable iff (rst)
    op_valid |=> stat_out[ENA_MSB:ENA_LSB] == $past(stat_in[ENA_MSB:ENA_LSB]));  // R5
  AST_PC_HOLD: assert property (@(posedge clk) disable iff (rst)
    op_valid |=> !trap_taken || (pc_out == $past(pc_in) && npc_out == $past(npc_in)));  // R6
  AST_PC_ADVANCE: assert property (@(posedge clk) disable iff (rst)
    op_valid |=> trap_taken ||
      (pc_out == $past(npc_in) && npc_out == $past(npc_in) + PC_W'(PC_STEP)));  // R7
endmodule

// File: tb/fpx_status_recorder_bench.sv
module fpx_status_recorder_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        op_valid = 1'b0;
  logic [4:0]  op_flags = '0;
  logic [63:0] stat_in = '0;
  logic [63:0] pc_in = '0;
  logic [63:0] npc_in = '0;
  logic        done, trap_taken;
  logic [63:0] stat_out, pc_out, npc_out;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  fpx_status_recorder u_fpx_status_recorder (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_flags(op_flags),
    .stat_in(stat_in), .pc_in(pc_in), .npc_in(npc_in),
    .done(done), .trap_taken(trap_taken), .stat_out(stat_out),
    .pc_out(pc_out), .npc_out(npc_out)
  );

  // Fields: flags, enables, acc_in, exp_trap, exp_cur, exp_acc
  // flag order (R1): invalid=4 overflow=3 underflow=2 divzero=1 inexact=0
  localparam int NV = 10;
  localparam logic [25:0] VEC [NV] = '{
    {5'b00000, 5'b00000, 5'b00000, 1'b0, 5'b00000, 5'b00000}, // R8 no flags
    {5'b10001, 5'b00000, 5'b00100, 1'b0, 5'b10001, 5'b10101}, // R4 accrue
    {5'b01000, 5'b01000, 5'b00011, 1'b1, 5'b01000, 5'b00011}, // R3 single
    {5'b11111, 5'b11111, 5'b00000, 1'b1, 5'b10000, 5'b00000}, // R3 invalid wins
    {5'b01110, 5'b00110, 5'b00000, 1'b1, 5'b00100, 5'b00000}, // R3 underflow > divzero
    {5'b00011, 5'b00011, 5'b01000, 1'b1, 5'b00010, 5'b01000}, // R3 divzero > inexact
    {5'b00001, 5'b11110, 5'b00000, 1'b0, 5'b00001, 5'b00001}, // R2 not enabled
    {5'b10101, 5'b00001, 5'b00000, 1'b1, 5'b00001, 5'b00000}, // R3 mask first
    {5'b01001, 5'b01001, 5'b11111, 1'b1, 5'b01000, 5'b11111}, // R5 acc kept
    {5'b00000, 5'b11111, 5'b01010, 1'b0, 5'b00000, 5'b01010}  // R8 clears current
  };

  localparam logic [63:0] BASE = 64'h5A5A_5A50_0000_1000;

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic issue(input logic [4:0] fl, input logic [63:0] st,
                       input logic [63:0] p, input logic [63:0] np);
    @(negedge clk);
    op_valid = 1'b1; op_flags = fl; stat_in = st; pc_in = p; npc_in = np;
    @(negedge clk);
    op_valid = 1'b0;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R9 reset done", {63'd0, done}, 64'd0);
    check("R9 reset trap", {63'd0, trap_taken}, 64'd0);
    check("R9 reset stat", stat_out, 64'd0);
    check("R9 reset pc", pc_out | npc_out, 64'd0);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      logic [4:0]  fl, en, acc, cur, eacc;
      logic        tr;
      logic [63:0] st, est, p, np;
      {fl, en, acc, tr, cur, eacc} = VEC[i];
      st  = BASE | (64'(en) << 23) | (64'(acc) << 5) | 64'h15;
      est = BASE | (64'(en) << 23) | (64'(eacc) << 5) | 64'(cur) | (64'(tr) << 14);
      p   = 64'h4000 + 64'(i) * 64'h40;
      np  = p + 64'd4;
      issue(fl, st, p, np);
      check($sformatf("R9 done vec%0d", i), {63'd0, done}, 64'd1);
      check($sformatf("R2 trap vec%0d", i), {63'd0, trap_taken}, {63'd0, tr});
      check($sformatf("R3/R4/R5 status vec%0d", i), stat_out, est);
      if (tr) begin
        check($sformatf("R6 pc vec%0d", i), pc_out, p);
        check($sformatf("R6 npc vec%0d", i), npc_out, np);
      end else begin
        check($sformatf("R7 pc vec%0d", i), pc_out, np);
        check($sformatf("R7 npc vec%0d", i), npc_out, np + 64'd4);
      end
    end

    // R7: following PC wraps at the top of the address space
    issue(5'b00000, BASE, 64'hFFFF_FFFF_FFFF_FFFA, 64'hFFFF_FFFF_FFFF_FFFE);
    check("R7 wrap pc", pc_out, 64'hFFFF_FFFF_FFFF_FFFE);
    check("R7 wrap npc", npc_out, 64'h0000_0000_0000_0002);

    // R5: a pre-set bit 14 passes through a retire without trap; R1 field placement
    issue(5'b00100, BASE | 64'h4000, 64'h100, 64'h104);
    check("R5 bit14 passes", stat_out, BASE | 64'h4000 | 64'h80 | 64'h04);
    check("R1 accrued at 9:5", {59'd0, stat_out[9:5]}, 64'd4);

    // R9: no request -> outputs hold, done low
    @(negedge clk);
    op_flags = 5'b11111; stat_in = 64'hFFFF_FFFF_FFFF_FFFF; npc_in = 64'h9999;
    @(negedge clk);
    check("R9 idle done", {63'd0, done}, 64'd0);
    check("R9 idle stat hold", stat_out, BASE | 64'h4000 | 64'h80 | 64'h04);
    check("R9 idle pc hold", pc_out, 64'h104);

    // R9: done lasts one cycle
    issue(5'b00000, BASE, 64'h10, 64'h14);
    @(negedge clk);
    check("R9 single pulse", {63'd0, done}, 64'd0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule